// File: doc/BRIEF.md
# Time-of-Day Event Counter with Alarm

This block keeps a 24-bit binary count of rising edges seen on an asynchronous tick input, such as a frame or line pulse. Software reaches it through three byte-wide register slots (low, middle and high byte of the count). A matching 24-bit alarm value is also written through those three slots, and a select input steers each write to either the live count or the alarm. Reads always return the count. The alarm itself is never readable.

Two mechanisms keep multi-byte accesses consistent. Reading the high byte captures all three bytes in a holding register, and later reads are served from it until the low byte is read. The live count keeps advancing underneath. Writing any count byte halts counting, and writing the low byte resumes it. Software therefore writes high, then middle, then low, and the clock starts at exactly the value it set.

Whenever the count changes, either through a tick or through a count write, and its new value equals the alarm, the block raises a one-cycle alarm strobe for an external interrupt collector.

Top module: `tod_event_counter`

## Requirements
- R1: A synchronous reset clears the count, the alarm, the read hold, `rdata` and `alarm_hit`, and leaves the counter running so that the next tick gives a count of 1.
- R2: Each rising edge of `tick_in`, after a two-flop synchroniser, adds one to the count modulo 2^24. A level held high for many cycles counts once, and 0xFFFFFF wraps to 0x000000.
- R3: Slot index `sel` 0 maps to count bits 7:0, 1 to bits 15:8 and 2 to bits 23:16. Index 3 reads as 0x00, and writes to index 3 have no effect.
- R4: With `alarm_sel`=1 a write loads the selected alarm byte and changes neither the count nor the running state. Reads return the count whatever `alarm_sel` is.
- R5: A count write (`alarm_sel`=0) to index 1 or 2 stops counting, and ticks seen while stopped are lost. A count write to index 0 loads that byte and restarts counting.
- R6: A read of index 2 while no hold is active captures all three count bytes. Later reads return the captured bytes until a read of index 0, which returns the captured low byte and then releases the hold. The count keeps advancing meanwhile.
- R7: Without an active hold, a read of index 0 or 1 returns the live count byte and sets up no hold.
- R8: `alarm_hit` is high for one cycle, in the cycle after a tick or count write that leaves the count equal to the alarm. An alarm write alone never raises it.
- R9: `rdata` is registered. It takes the selected value one cycle after `rd_en` and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Asynchronous event input, counted on rising edges |
| sel | input | 2 | Byte slot index (0 low, 1 middle, 2 high) |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| alarm_sel | input | 1 | 1 steers writes to the alarm, 0 to the count |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data byte |
| alarm_hit | output | 1 | One-cycle alarm match strobe |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle. They also assume that `tick_in` stays at each level for several clocks, so that successive synchronised edges are at least two cycles apart and a count change that no write explains must be a single increment. The stimulus drives each access as a one-cycle strobe followed by an idle cycle, and holds every tick level for at least four clocks. Reset is held for several cycles, so history checks taken just after reset see only reset values.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int BYTE_W = 8;
  localparam int LO_IDX = 0;
endpackage

// File: rtl/tod_sync_edge.sv
module tod_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] chain_q;

  generate
    for (genvar g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/tod_core.sv
module tod_core
  import tod_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int SEL_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise,
  input  logic              wr_en,
  input  logic              asel,
  input  logic [SEL_W-1:0]  idx,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              run_q,
  output logic              hit_q
);
  localparam int NB = CNT_W / BYTE_W;

  logic [CNT_W-1:0] alarm_q, cnt_nxt, alarm_nxt;
  logic             run_nxt, chg, idx_ok, time_wr, al_wr;

  assign idx_ok  = int'(idx) < NB;
  assign time_wr = wr_en & ~asel & idx_ok;
  assign al_wr   = wr_en &  asel & idx_ok;

  always_comb begin
    cnt_nxt   = cnt_q;
    alarm_nxt = alarm_q;
    run_nxt   = run_q;
    chg       = 1'b0;
    if (al_wr)
      alarm_nxt[int'(idx)*BYTE_W +: BYTE_W] = wdata;
    if (time_wr) begin
      cnt_nxt[int'(idx)*BYTE_W +: BYTE_W] = wdata;
      run_nxt = (int'(idx) == LO_IDX);
      chg     = 1'b1;
    end else if (rise && run_q) begin
      cnt_nxt = cnt_q + 1'b1;
      chg     = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      alarm_q <= '0;
      run_q   <= 1'b1;
      hit_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt;
      alarm_q <= alarm_nxt;
      run_q   <= run_nxt;
      hit_q   <= chg && (cnt_nxt == alarm_q);
    end
  end
endmodule

// File: rtl/tod_read_hold.sv
module tod_read_hold
  import tod_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int SEL_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [SEL_W-1:0]  idx,
  input  logic [CNT_W-1:0]  cnt,
  output logic [BYTE_W-1:0] rdata_q,
  output logic              hold_q
);
  localparam int NB     = CNT_W / BYTE_W;
  localparam int HI_IDX = NB - 1;

  logic [CNT_W-1:0] held_q, view;

  assign view = hold_q ? held_q : cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q  <= '0;
      hold_q  <= 1'b0;
      rdata_q <= '0;
    end else if (rd_en) begin
      if (int'(idx) < NB) rdata_q <= view[int'(idx)*BYTE_W +: BYTE_W];
      else                rdata_q <= '0;
      if (int'(idx) == HI_IDX && !hold_q) begin
        hold_q <= 1'b1;
        held_q <= cnt;
      end else if (int'(idx) == LO_IDX) begin
        hold_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tod_event_counter.sv
module tod_event_counter
  import tod_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick_in,
  input  logic [1:0]  sel,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic        alarm_sel,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic        alarm_hit
);
  localparam int SEL_W = 2;

  logic             tick_rise;
  logic [CNT_W-1:0] count_w;
  logic             run_w;
  logic             hold_w;

  tod_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(tick_in), .rise(tick_rise)
  );

  tod_core #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_core (
    .clk(clk), .rst(rst), .rise(tick_rise), .wr_en(wr_en),
    .asel(alarm_sel), .idx(sel), .wdata(wdata),
    .cnt_q(count_w), .run_q(run_w), .hit_q(alarm_hit)
  );

  tod_read_hold #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_hold (
    .clk(clk), .rst(rst), .rd_en(rd_en), .idx(sel), .cnt(count_w),
    .rdata_q(rdata), .hold_q(hold_w)
  );
endmodule

// File: rtl/tod_event_counter_chk.sv
module tod_event_counter_chk #(
  parameter int CNT_W = 24,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             rd_en,
  input logic             alarm_sel,
  input logic [SEL_W-1:0] sel,
  input logic             alarm_hit,
  input logic [CNT_W-1:0] count_w,
  input logic             run_w,
  input logic             hold_w
);
  localparam int NB = CNT_W / 8;

  // R2: an unexplained change of the count is a single increment
  a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
    (!$stable(count_w) && !$past(wr_en)) |-> count_w == CNT_W'($past(count_w) + 1'b1));

  // R4: alarm writes leave the running state untouched
  a_r4_alarm_keeps_run: assert property (@(posedge clk) disable iff (rst)
    (wr_en && alarm_sel) |=> $stable(run_w));

  // R5: upper count writes stop counting
  a_r5_stop_on_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !alarm_sel && sel != '0 && int'(sel) < NB) |=> !run_w);

  // R5: low count write restarts
  a_r5_start_on_low: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !alarm_sel && sel == '0) |=> run_w);

  // R5: stopped count does not move without a write
  a_r5_halted_stable: assert property (@(posedge clk) disable iff (rst)
    (!run_w && !wr_en) |=> $stable(count_w));

  // R6: high-byte read sets the hold
  a_r6_freeze: assert property (@(posedge clk) disable iff (rst)
    (rd_en && int'(sel) == NB - 1) |=> hold_w);

  // R6: low-byte read releases the hold
  a_r6_release: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == '0) |=> !hold_w);

  // R8: a strobe needs a count change or a count write just before
  a_r8_hit_cause: assert property (@(posedge clk) disable iff (rst)
    alarm_hit |-> (!$stable(count_w) || $past(wr_en && !alarm_sel)));
endmodule

bind tod_event_counter tod_event_counter_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .alarm_sel(alarm_sel),
  .sel(sel), .alarm_hit(alarm_hit), .count_w(count_w), .run_w(run_w), .hold_w(hold_w)
);

// File: tb/test_tod_event_counter.sv
module test_tod_event_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_in = 1'b0;
  logic [1:0] sel = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0, alarm_sel = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       alarm_hit;

  int tests = 0, fails = 0, hits = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tod_event_counter i_tod_event_counter (
    .clk(clk), .rst(rst), .tick_in(tick_in), .sel(sel), .wr_en(wr_en),
    .rd_en(rd_en), .alarm_sel(alarm_sel), .wdata(wdata), .rdata(rdata),
    .alarm_hit(alarm_hit)
  );

  always @(negedge clk) if (!rst && alarm_hit) hits++;

  // entry: {req[3:0], op[1:0] (0 write,1 read,2 tick), sel[1:0], asel, data[7:0], exp[7:0]}
  localparam int NV = 32;
  localparam logic [24:0] VEC [0:NV-1] = '{
    {4'd3, 2'd0, 2'd2, 1'b0, 8'h12, 8'h00},  // R3 time writes high, mid, low
    {4'd3, 2'd0, 2'd1, 1'b0, 8'h34, 8'h00},
    {4'd3, 2'd0, 2'd0, 1'b0, 8'h56, 8'h00},
    {4'd3, 2'd1, 2'd0, 1'b0, 8'h00, 8'h56},
    {4'd3, 2'd1, 2'd1, 1'b0, 8'h00, 8'h34},
    {4'd6, 2'd1, 2'd2, 1'b0, 8'h00, 8'h12},  // R6 freeze
    {4'd6, 2'd2, 2'd0, 1'b0, 8'h00, 8'h00},
    {4'd6, 2'd1, 2'd1, 1'b0, 8'h00, 8'h34},
    {4'd6, 2'd1, 2'd0, 1'b0, 8'h00, 8'h56},  // held low, releases
    {4'd7, 2'd1, 2'd0, 1'b0, 8'h00, 8'h57},  // R7 live value
    {4'd5, 2'd0, 2'd2, 1'b0, 8'hFF, 8'h00},  // R5 stop
    {4'd5, 2'd2, 2'd0, 1'b0, 8'h00, 8'h00},
    {4'd5, 2'd1, 2'd0, 1'b0, 8'h00, 8'h57},  // tick lost
    {4'd5, 2'd0, 2'd0, 1'b0, 8'hFF, 8'h00},  // restart
    {4'd5, 2'd2, 2'd0, 1'b0, 8'h00, 8'h00},
    {4'd2, 2'd1, 2'd1, 1'b0, 8'h00, 8'h35},
    {4'd2, 2'd1, 2'd0, 1'b0, 8'h00, 8'h00},
    {4'd2, 2'd0, 2'd2, 1'b0, 8'hFF, 8'h00},  // R2 wrap setup
    {4'd2, 2'd0, 2'd1, 1'b0, 8'hFF, 8'h00},
    {4'd2, 2'd0, 2'd0, 1'b0, 8'hFF, 8'h00},
    {4'd2, 2'd2, 2'd0, 1'b0, 8'h00, 8'h00},
    {4'd2, 2'd1, 2'd2, 1'b0, 8'h00, 8'h00},
    {4'd2, 2'd1, 2'd1, 1'b0, 8'h00, 8'h00},
    {4'd2, 2'd1, 2'd0, 1'b0, 8'h00, 8'h00},
    {4'd3, 2'd1, 2'd3, 1'b0, 8'h00, 8'h00},  // R3 index 3 reads zero
    {4'd3, 2'd0, 2'd3, 1'b0, 8'hAA, 8'h00},
    {4'd3, 2'd1, 2'd0, 1'b0, 8'h00, 8'h00},
    {4'd3, 2'd1, 2'd1, 1'b0, 8'h00, 8'h00},
    {4'd4, 2'd0, 2'd0, 1'b1, 8'h77, 8'h00},  // R4 alarm write
    {4'd4, 2'd1, 2'd0, 1'b0, 8'h00, 8'h00},
    {4'd4, 2'd1, 2'd1, 1'b1, 8'h00, 8'h00},
    {4'd4, 2'd1, 2'd2, 1'b0, 8'h00, 8'h00}
  };

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic a, input logic [7:0] d);
    @(negedge clk); sel = s; alarm_sel = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; alarm_sel = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, input logic a, output logic [7:0] q);
    @(negedge clk); sel = s; alarm_sel = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; alarm_sel = 1'b0; q = rdata;
  endtask

  task automatic tick(input int high_cycles);
    @(negedge clk); tick_in = 1'b1;
    repeat (high_cycles) @(negedge clk);
    tick_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [7:0] q;
    int h0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rdata after reset", int'(rdata), 0);
    check("R1 alarm_hit after reset", int'(alarm_hit), 0);
    rd(2'd0, 1'b0, q); check("R1 count low after reset", int'(q), 0);

    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      v = VEC[i];
      case (v[20:19])
        2'd0: wr(v[18:17], v[16], v[15:8]);
        2'd1: begin
          rd(v[18:17], v[16], q);
          check($sformatf("R%0d table entry %0d", v[24:21], i), int'(q), int'(v[7:0]));
        end
        default: tick(4);
      endcase
    end

    // R1 reset mid-run, counter runs afterwards
    rd(2'd2, 1'b0, q);
    @(negedge clk); rst = 1'b1; repeat (3) @(negedge clk); rst = 1'b0;
    rd(2'd1, 1'b0, q); check("R1 mid after reset", int'(q), 0);
    tick(4);
    rd(2'd0, 1'b0, q); check("R1 running after reset", int'(q), 1);

    // R8 alarm write alone does not strobe; R4 alarm writes keep counting
    h0 = hits;
    wr(2'd2, 1'b1, 8'h00); wr(2'd1, 1'b1, 8'h00); wr(2'd0, 1'b1, 8'h03);
    repeat (2) @(negedge clk);
    check("R8 no strobe on alarm write", hits - h0, 0);
    tick(4);
    rd(2'd0, 1'b0, q); check("R4 counting after alarm writes", int'(q), 2);
    h0 = hits;
    tick(4);
    check("R8 strobe on tick match", hits - h0, 1);
    tick(4);
    check("R8 no strobe past match", hits - h0, 1);

    // R9 rdata holds without a read
    rd(2'd0, 1'b0, q); check("R9 read value", int'(q), 4);
    tick(4);
    check("R9 rdata held", int'(rdata), 4);

    // R2 long level counts once
    tick(20);
    rd(2'd0, 1'b0, q); check("R2 long level single count", int'(q), 6);

    // R8 count write that lands on the alarm
    h0 = hits;
    wr(2'd2, 1'b0, 8'h00); wr(2'd1, 1'b0, 8'h00); wr(2'd0, 1'b0, 8'h03);
    repeat (2) @(negedge clk);
    check("R8 strobe on time write match", hits - h0, 1);
    wr(2'd0, 1'b1, 8'h03);
    repeat (2) @(negedge clk);
    check("R8 alarm rewrite no strobe", hits - h0, 1);

    done = 1;
    summary();
  end
endmodule